// File: doc/BRIEF.md
# Reset Sequencer With Strap Capture

This block turns a raw reset request and a power-good indication into a clean, minimum-width reset for a processor core. It tells two kinds of reset apart. A cold reset follows loss of power. Its minimum width is one millisecond, counted in clocks from a parameter that gives the clock frequency in kHz. A warm reset is a request that arrives while power is stable. It has a short minimum width, 15 clocks by default. The reset output is released only once the minimum that applies has been met and the request has gone away.

On the clock edge where the reset output is released, the block captures three configuration straps: a 3-bit bus-frequency ratio, a flush request and a cache-ready indication. The flush strap is taken from its value one edge earlier. The captured values are then held until the next release. For two edges after each release the block watches the strap pins. If any of them moves within that window, it sets a sticky hold-violation flag, which clears at the next reset assertion.

There is no data stream at this block's edge. Every pin is a plain control or status level, with no valid/ready handshake and no back-pressure. The raw request is synchronised inside the block. The strap pins must be stable at the clock edges around release.

Top module: `rst_seq_top`

## Requirements
- R1: While pwr_good is low, rst_out is high (forced asynchronously), the next release uses the cold minimum, and cfg_busfreq, cfg_flush, cfg_cready and strap_hold_err are all 0.
- R2: After pwr_good rises with no request present, rst_out stays high for exactly CLK_KHZ+2 clock cycles (two cycles of power-good synchronisation, then CLK_KHZ cycles of counting) and then falls.
- R3: A request on rst_req while rst_out is low raises rst_out on the third rising edge after the request appears. A request seen high for a single cycle yields a reset exactly WARM_CYC cycles wide.
- R4: While the synchronised request stays high, rst_out stays high. If the request is held for L cycles with L at least WARM_CYC, rst_out is high for exactly L cycles.
- R5: cfg_busfreq and cfg_cready take the values on strap_busfreq and strap_cready at the rising edge where rst_out falls.
- R6: cfg_flush takes the value that strap_flush had at the rising edge just before the edge where rst_out falls.
- R7: While rst_out stays low, cfg_busfreq, cfg_flush and cfg_cready do not change, whatever the strap pins do.
- R8: strap_hold_err becomes 1 if any strap pin, sampled on either of the two rising edges after the release edge, differs from its value at the release edge. Changes first sampled on the third edge or later do not set it.
- R9: strap_hold_err stays 1 until the next reset assertion. It is 0 from the second edge after rst_out rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply and clock valid. Low means power is absent and the block is reset asynchronously |
| rst_req | input | 1 | Raw reset request, active high, may be asynchronous |
| strap_busfreq | input | 3 | Bus-frequency ratio strap pins |
| strap_flush | input | 1 | Flush-request strap pin |
| strap_cready | input | 1 | Cache-ready strap pin |
| rst_out | output | 1 | Clean reset to the core, active high |
| cfg_busfreq | output | 3 | Captured bus-frequency ratio |
| cfg_flush | output | 1 | Captured flush request |
| cfg_cready | output | 1 | Captured cache-ready indication |
| strap_hold_err | output | 1 | Sticky flag: a strap moved within two edges after release |

## Verification
The bench measures the exact width of every reset pulse: the cold pulse after power-good rises, a one-cycle warm request and a long held request. A design with a wrong count, a missing synchronisation stage, or a release while the request is still high would show up as a width that is off. The flush strap is toggled on exactly the edge before release, and a design that captured it on the release edge would latch the wrong level. Strap pins are moved on the first edge after release and again on the third edge after release. This catches a violation window that is too short, too long or missing. The bench also checks that the flag clears once a new reset starts and that the captured values ignore later pin activity.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int BF_W = 3;

  typedef enum logic {
    MODE_WARM = 1'b0,
    MODE_COLD = 1'b1
  } rst_mode_e;

  typedef struct packed {
    logic [BF_W-1:0] busfreq;
    logic            flush;
    logic            cready;
  } strap_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) sh_q <= '0;
        else         sh_q <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
  import rstseq_pkg::*;
#(
  parameter int CLK_KHZ  = 125000,
  parameter int WARM_CYC = 15
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic pg_s,
  input  logic req_s,
  output logic rst_q,
  output logic rel_now
);
  localparam int COLD_CYC = CLK_KHZ;
  localparam int MAX_CYC  = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  rst_mode_e      mode_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  min_m1;

  assign min_m1  = (mode_q == MODE_COLD) ? CW'(COLD_CYC - 1) : CW'(WARM_CYC - 1);
  assign rel_now = rst_q && pg_s && (cnt_q >= min_m1) && !req_s;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      rst_q  <= 1'b1;
      mode_q <= MODE_COLD;
      cnt_q  <= '0;
    end else if (!rst_q) begin
      if (req_s) begin
        rst_q  <= 1'b1;
        mode_q <= MODE_WARM;
        cnt_q  <= '0;
      end
    end else if (rel_now) begin
      rst_q <= 1'b0;
    end else if (pg_s && (cnt_q < min_m1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Independent run-length counter for checking only
  logic [31:0] run_q;
  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good)                  run_q <= '0;
    else if (!rst_q)                run_q <= '0;
    else if (run_q < 32'(MAX_CYC))  run_q <= run_q + 1;

  // R2
  min_width_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(rst_q) |-> (run_q >= 32'((mode_q == MODE_COLD) ? COLD_CYC : WARM_CYC)));

  // R3
  warm_entry_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (!rst_q && req_s) |=> (rst_q && mode_q == MODE_WARM));
endmodule

// File: rtl/rstseq_straps.sv
module rstseq_straps
  import rstseq_pkg::*;
(
  input  logic   clk,
  input  logic   pwr_good,
  input  logic   rst_q,
  input  logic   rel_now,
  input  strap_t pins,
  output strap_t cfg,
  output logic   hold_err
);
  logic   flush_d;
  strap_t snap_q;
  logic [1:0] win_q;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      flush_d  <= 1'b0;
      cfg      <= '0;
      snap_q   <= '0;
      win_q    <= '0;
      hold_err <= 1'b0;
    end else begin
      flush_d <= pins.flush;
      if (rel_now) begin
        cfg.busfreq <= pins.busfreq;
        cfg.flush   <= flush_d;
        cfg.cready  <= pins.cready;
        snap_q      <= pins;
        win_q       <= 2'd2;
      end else if (win_q != 2'd0) begin
        win_q <= win_q - 2'd1;
        if (pins != snap_q) hold_err <= 1'b1;
      end
      if (rst_q && !rel_now) hold_err <= 1'b0;
    end
  end

  // R8
  err_window_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(hold_err) |-> ($past(win_q) != 2'd0));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (hold_err && !rst_q) |=> hold_err);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rstseq_pkg::*;
#(
  parameter int CLK_KHZ  = 125000,
  parameter int WARM_CYC = 15,
  parameter int SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            pwr_good,
  input  logic            rst_req,
  input  logic [BF_W-1:0] strap_busfreq,
  input  logic            strap_flush,
  input  logic            strap_cready,
  output logic            rst_out,
  output logic [BF_W-1:0] cfg_busfreq,
  output logic            cfg_flush,
  output logic            cfg_cready,
  output logic            strap_hold_err
);
  logic   pg_s, req_s, rst_q, rel_now;
  strap_t pins, cfg;

  rstseq_sync #(.STAGES(SYNC_STG)) u_pg_sync (
    .clk(clk), .arst_n(pwr_good), .d(1'b1), .q(pg_s));

  rstseq_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(clk), .arst_n(pwr_good), .d(rst_req), .q(req_s));

  rstseq_timer #(.CLK_KHZ(CLK_KHZ), .WARM_CYC(WARM_CYC)) u_timer (
    .clk(clk), .pwr_good(pwr_good), .pg_s(pg_s), .req_s(req_s),
    .rst_q(rst_q), .rel_now(rel_now));

  assign pins = '{busfreq: strap_busfreq, flush: strap_flush, cready: strap_cready};

  rstseq_straps u_straps (
    .clk(clk), .pwr_good(pwr_good), .rst_q(rst_q), .rel_now(rel_now),
    .pins(pins), .cfg(cfg), .hold_err(strap_hold_err));

  assign rst_out     = rst_q;
  assign cfg_busfreq = cfg.busfreq;
  assign cfg_flush   = cfg.flush;
  assign cfg_cready  = cfg.cready;

  // R1
  pg_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !pg_s |-> rst_out);

  // R4
  req_extends_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (rst_out && req_s) |=> rst_out);

  // R7
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (!rst_out && $past(!rst_out)) |-> ($stable(cfg_busfreq) && $stable(cfg_flush) && $stable(cfg_cready)));
endmodule

// File: tb/rst_seq_top_tb.sv
module rst_seq_top_tb;
  localparam int KHZ  = 40;
  localparam int WARM = 15;

  logic clk = 1'b0;
  logic pwr_good, rst_req, strap_flush, strap_cready;
  logic [2:0] strap_busfreq;
  logic rst_out, cfg_flush, cfg_cready, strap_hold_err;
  logic [2:0] cfg_busfreq;

  always #4 clk = ~clk;  // 125 MHz

  rst_seq_top #(.CLK_KHZ(KHZ), .WARM_CYC(WARM)) u_dut (
    .clk(clk), .pwr_good(pwr_good), .rst_req(rst_req),
    .strap_busfreq(strap_busfreq), .strap_flush(strap_flush), .strap_cready(strap_cready),
    .rst_out(rst_out), .cfg_busfreq(cfg_busfreq), .cfg_flush(cfg_flush),
    .cfg_cready(cfg_cready), .strap_hold_err(strap_hold_err));

  typedef struct {
    int         hi;
    logic [2:0] bf;
    logic       fl;
    logic       cr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: measures each reset pulse and compares against the scoreboard
  int hi_cnt = 0;
  logic prev_rst = 1'b1;
  always @(negedge clk) begin
    if (!pwr_good) hi_cnt = 0;
    else if (rst_out) hi_cnt++;
    else if (prev_rst) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected release", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(hi_cnt == e.hi, {e.tag, " width"}, hi_cnt, e.hi);
        check(cfg_busfreq == e.bf, "R5 busfreq capture", cfg_busfreq, e.bf);
        check(cfg_cready == e.cr, "R5 cready capture", cfg_cready, e.cr);
        check(cfg_flush == e.fl, "R6 flush capture", cfg_flush, e.fl);
      end
      hi_cnt = 0;
    end
    prev_rst = rst_out;
  end

  task automatic wait_release();
    @(negedge clk);
    while (rst_out) @(negedge clk);
  endtask

  task automatic push(input int hi, input logic [2:0] bf, input logic fl, input logic cr, input string tag);
    exp_t e;
    e.hi = hi; e.bf = bf; e.fl = fl; e.cr = cr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic run();
    pwr_good = 1'b0; rst_req = 1'b0;
    strap_busfreq = 3'd5; strap_flush = 1'b1; strap_cready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rst_out == 1'b1, "R1 rst_out", rst_out, 1);
    check(cfg_busfreq == 3'd0, "R1 cfg_busfreq", cfg_busfreq, 0);
    check(strap_hold_err == 1'b0, "R1 hold_err", strap_hold_err, 0);

    // R2 cold reset
    push(KHZ + 2, 3'd5, 1'b1, 1'b0, "R2 cold");
    pwr_good = 1'b1;
    wait_release();
    // R8: strap moves on first edge after release
    strap_busfreq = 3'd6;
    repeat (3) @(negedge clk);
    check(strap_hold_err == 1'b1, "R8 early change", strap_hold_err, 1);
    check(cfg_busfreq == 3'd5, "R7 cfg held", cfg_busfreq, 5);

    // R3 warm single-cycle request
    strap_busfreq = 3'd3; strap_flush = 1'b0; strap_cready = 1'b1;
    repeat (2) @(negedge clk);
    check(strap_hold_err == 1'b1, "R9 sticky", strap_hold_err, 1);
    push(WARM, 3'd3, 1'b0, 1'b1, "R3 warm");
    rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    check(rst_out == 1'b0, "R3 edge1", rst_out, 0);
    @(negedge clk);
    check(rst_out == 1'b0, "R3 edge2", rst_out, 0);
    @(negedge clk);
    check(rst_out == 1'b1, "R3 edge3", rst_out, 1);
    @(negedge clk);
    check(strap_hold_err == 1'b0, "R9 cleared", strap_hold_err, 0);
    wait_release();
    repeat (4) @(negedge clk);
    check(strap_hold_err == 1'b0, "R8 stable straps", strap_hold_err, 0);

    // R6 flush toggled on the edge before release; R8 late change
    strap_busfreq = 3'd2; strap_cready = 1'b0; strap_flush = 1'b0;
    @(negedge clk);
    push(WARM, 3'd2, 1'b1, 1'b0, "R3 warm2");
    rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    repeat (15) @(negedge clk);
    strap_flush = 1'b1;
    @(negedge clk);
    strap_flush = 1'b0;
    @(negedge clk);
    check(rst_out == 1'b0, "R3 release edge", rst_out, 0);
    repeat (2) @(negedge clk);
    strap_busfreq = 3'd7; strap_cready = 1'b1;
    repeat (3) @(negedge clk);
    check(strap_hold_err == 1'b0, "R8 late change", strap_hold_err, 0);
    check(cfg_busfreq == 3'd2, "R7 busfreq held", cfg_busfreq, 2);
    check(cfg_cready == 1'b0, "R7 cready held", cfg_cready, 0);

    // R4 long request
    strap_busfreq = 3'd1; strap_flush = 1'b1; strap_cready = 1'b1;
    @(negedge clk);
    push(40, 3'd1, 1'b1, 1'b1, "R4 long");
    rst_req = 1'b1;
    repeat (40) @(negedge clk);
    rst_req = 1'b0;
    wait_release();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      begin run(); end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule